// File: doc/BRIEF.md
# Three-Buffer CAN Transmit Scheduler

This block decides which of three outgoing message buffers goes onto the CAN bus next and tracks each buffer's job until it finishes. Host software locks a buffer, fills it, and submits the job with a one-cycle submit pulse for that buffer. The buffer is then marked ready. Each time the bus goes idle, the scheduler picks the highest-numbered buffer that is ready and locked, asks the protocol engine to start it, and marks that buffer busy while the frame is on the wire.

The protocol engine reports each attempt as a success, a lost arbitration or an error. A successful send retires the job and raises the transmit-complete flag. A failed attempt raises the transmit-error flag. After a failure the job stays queued for another attempt, unless retries are disabled. A job is withdrawn in any of these cases:
- its buffer is unlocked;
- the node is bus-off;
- retries are disabled and the attempt fails.

A higher-numbered buffer that becomes ready pre-empts the job in flight. The pre-empted job stays queued and competes again at the next idle point. Both flags are sticky until the host clears them by writing one. A single interrupt line merges the two flags, each gated by its own enable. Frame serialization is handled elsewhere.

Top module: `can_tx_scheduler`

## Requirements
- R1: A submit pulse on buffer i while lockIn[i] is 1 sets rdyOut[i] at the next clock edge. A submit pulse while lockIn[i] is 0 leaves rdyOut[i] at 0.
- R2: When lockIn[i] is 0, rdyOut[i] is 0 after the next edge. If buffer i was busy, busyOut[i] also clears at that edge.
- R3: Buffers are numbered 0 to 2. When a start is issued, startIdx is the highest-numbered buffer whose ready and lock bits are both 1.
- R4: startReq is 1 in a cycle exactly when all of the following hold: no job is in flight, busIdle is 1, busOff is 0, and at least one buffer is both ready and locked. At the next edge, busyOut has only the started buffer's bit set.
- R5: If arbLost or txErr arrives during a job while noRetry is 0, the job's busy bit clears, its ready bit stays set, errFlag sets, and the same buffer is started again at the next idle point.
- R6: If a failure arrives while noRetry is 1, the job's ready bit also clears.
- R7: If txDone arrives during a job, that buffer's ready and busy bits clear and txFlag sets.
- R8: While busOff is 1, no start is issued, and every ready and busy bit is 0 after the next edge.
- R9: During a job, if a higher-numbered buffer is ready and locked, the job's busy bit clears and its ready bit stays set. If txDone arrives in the same cycle, completion takes precedence.
- R10: txFlag and errFlag stay set until cleared by writing one to flagClr: bit 0 clears txFlag and bit 1 clears errFlag. If a flag is set and cleared in the same cycle, it stays set.
- R11: irq equals (txFlag AND txIe) OR (errFlag AND errIe).
- R12: Engine results that arrive while no job is in flight change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockIn | input | 3 | Per-buffer lock bits |
| submitIn | input | 3 | Per-buffer job submit pulses |
| noRetry | input | 1 | Disable automatic retransmission |
| busIdle | input | 1 | Bus is idle; a frame may start |
| busOff | input | 1 | Node is in bus-off |
| txDone | input | 1 | Engine: current frame sent successfully |
| arbLost | input | 1 | Engine: arbitration lost |
| txErr | input | 1 | Engine: transmission error |
| txIe | input | 1 | Enable for the transmit-complete interrupt |
| errIe | input | 1 | Enable for the transmit-error interrupt |
| flagClr | input | 2 | Write-one-to-clear: bit 0 clears txFlag, bit 1 clears errFlag |
| startReq | output | 1 | Start request to the engine |
| startIdx | output | 2 | Buffer selected for the start |
| rdyOut | output | 3 | Per-buffer ready status |
| busyOut | output | 3 | Per-buffer busy status |
| txFlag | output | 1 | Sticky transmit-complete flag |
| errFlag | output | 1 | Sticky transmit-error flag |
| irq | output | 1 | Gated interrupt line |

## Verification
Two events can land in the same cycle. A job can complete at the moment a higher-numbered buffer becomes ready and would pre-empt it. A flag can also be set by an engine result in the same cycle that the host clears it. Directed sequences force both coincidences: a higher buffer is submitted one cycle before txDone arrives, and flagClr is pulsed together with a failure. The bench then expects the finished job to be retired with txFlag set, and the flag to survive the clear. Random traffic, checked cycle by cycle against a reference model, also hits these overlaps alongside unlocks, bus-off and results that arrive with no job in flight.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } ctrlState_e;

  typedef struct packed {
    logic launch;   // mark jobIdx busy
    logic finish;   // release busy of jobIdx
    logic dropRdy;  // retire the job in jobIdx
    logic setTx;    // completion flag
    logic setErr;   // failure flag
  } txStrobe_t;

endpackage

// File: rtl/can_tx_ctrl.sv
module can_tx_ctrl
  import can_tx_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] rdyIn,
  input  logic [NUM_BUF-1:0] lockIn,
  input  logic               busIdle,
  input  logic               busOff,
  input  logic               noRetry,
  input  logic               txDone,
  input  logic               arbLost,
  input  logic               txErr,
  output txStrobe_t          strobe,
  output logic [IDX_W-1:0]   jobIdx,
  output logic               startReq
);

  ctrlState_e        state, nextState;
  logic [IDX_W-1:0]  curIdx, selIdx;
  logic [NUM_BUF-1:0] pend;
  logic              anyPend, higherPend;

  always_comb begin
    pend       = rdyIn & lockIn;
    anyPend    = |pend;
    selIdx     = '0;
    higherPend = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (pend[i]) selIdx = IDX_W'(i);
      if (pend[i] && (IDX_W'(i) > curIdx)) higherPend = 1'b1;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    startReq  = 1'b0;
    jobIdx    = (state == ST_IDLE) ? selIdx : curIdx;
    case (state)
      ST_IDLE: begin
        if (busIdle && !busOff && anyPend) begin
          startReq      = 1'b1;
          strobe.launch = 1'b1;
          nextState     = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (busOff) begin
          strobe.finish  = 1'b1;
          strobe.dropRdy = 1'b1;
          nextState      = ST_IDLE;
        end else if (!lockIn[curIdx]) begin
          strobe.finish = 1'b1;
          nextState     = ST_IDLE;
        end else if (txDone) begin
          strobe.finish  = 1'b1;
          strobe.dropRdy = 1'b1;
          strobe.setTx   = 1'b1;
          nextState      = ST_IDLE;
        end else if (arbLost || txErr) begin
          strobe.finish  = 1'b1;
          strobe.setErr  = 1'b1;
          strobe.dropRdy = noRetry;
          nextState      = ST_IDLE;
        end else if (higherPend) begin
          strobe.finish = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curIdx <= '0;
    end else begin
      state <= nextState;
      if (strobe.launch) curIdx <= selIdx;
    end
  end

  assert_start_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> (busIdle && !busOff));

  assert_start_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !startReq);

  assert_prio_R3: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> (((pend >> jobIdx) >> 1) == '0));

endmodule

// File: rtl/can_tx_status.sv
module can_tx_status
  import can_tx_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] lockIn,
  input  logic [NUM_BUF-1:0] submitIn,
  input  logic               busOff,
  input  txStrobe_t          strobe,
  input  logic [IDX_W-1:0]   jobIdx,
  input  logic [1:0]         flagClr,
  input  logic               txIe,
  input  logic               errIe,
  output logic [NUM_BUF-1:0] rdyOut,
  output logic [NUM_BUF-1:0] busyOut,
  output logic               txFlag,
  output logic               errFlag,
  output logic               irq
);

  logic [NUM_BUF-1:0] rdyQ, busyQ;
  logic               txFlagQ, errFlagQ;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic hit;
    assign hit = (jobIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN)                           rdyQ[i] <= 1'b0;
      else if (busOff || !lockIn[i])       rdyQ[i] <= 1'b0;
      else if (strobe.dropRdy && hit)      rdyQ[i] <= 1'b0;
      else if (submitIn[i])                rdyQ[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                           busyQ[i] <= 1'b0;
      else if (strobe.launch && hit)       busyQ[i] <= 1'b1;
      else if (strobe.finish && hit)       busyQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFlagQ  <= 1'b0;
      errFlagQ <= 1'b0;
    end else begin
      txFlagQ  <= strobe.setTx  | (txFlagQ  & ~flagClr[0]);
      errFlagQ <= strobe.setErr | (errFlagQ & ~flagClr[1]);
    end
  end

  assign rdyOut  = rdyQ;
  assign busyOut = busyQ;
  assign txFlag  = txFlagQ;
  assign errFlag = errFlagQ;
  assign irq     = (txFlagQ & txIe) | (errFlagQ & errIe);

  assert_busy_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busyQ));

  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((rdyQ & ~$past(lockIn)) == '0));

  assert_busoff_R8: assert property (@(posedge clk) disable iff (!rstN)
    busOff |=> (rdyQ == '0));

  assert_tx_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setTx |=> txFlagQ);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlagQ && !flagClr[1]) |=> errFlagQ);

endmodule

// File: rtl/can_tx_scheduler.sv
module can_tx_scheduler
  import can_tx_pkg::*;
#(
  parameter int NUM_BUF = 3,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] lockIn,
  input  logic [NUM_BUF-1:0] submitIn,
  input  logic               noRetry,
  input  logic               busIdle,
  input  logic               busOff,
  input  logic               txDone,
  input  logic               arbLost,
  input  logic               txErr,
  input  logic               txIe,
  input  logic               errIe,
  input  logic [1:0]         flagClr,
  output logic               startReq,
  output logic [IDX_W-1:0]   startIdx,
  output logic [NUM_BUF-1:0] rdyOut,
  output logic [NUM_BUF-1:0] busyOut,
  output logic               txFlag,
  output logic               errFlag,
  output logic               irq
);

  txStrobe_t        strobe;
  logic [IDX_W-1:0] jobIdx;

  can_tx_ctrl #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdyIn    (rdyOut),
    .lockIn   (lockIn),
    .busIdle  (busIdle),
    .busOff   (busOff),
    .noRetry  (noRetry),
    .txDone   (txDone),
    .arbLost  (arbLost),
    .txErr    (txErr),
    .strobe   (strobe),
    .jobIdx   (jobIdx),
    .startReq (startReq)
  );

  can_tx_status #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_status (
    .clk      (clk),
    .rstN     (rstN),
    .lockIn   (lockIn),
    .submitIn (submitIn),
    .busOff   (busOff),
    .strobe   (strobe),
    .jobIdx   (jobIdx),
    .flagClr  (flagClr),
    .txIe     (txIe),
    .errIe    (errIe),
    .rdyOut   (rdyOut),
    .busyOut  (busyOut),
    .txFlag   (txFlag),
    .errFlag  (errFlag),
    .irq      (irq)
  );

  assign startIdx = jobIdx;

endmodule

// File: tb/tb_can_tx_scheduler.sv
module tb_can_tx_scheduler;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NB-1:0] lockIn = '0, submitIn = '0;
  logic noRetry = 0, busIdle = 0, busOff = 0, txDone = 0, arbLost = 0, txErr = 0;
  logic txIe = 1, errIe = 1;
  logic [1:0] flagClr = '0;
  logic startReq, txFlag, errFlag, irq;
  logic [1:0] startIdx;
  logic [NB-1:0] rdyOut, busyOut;

  int checks = 0, errors = 0;

  // reference state
  logic [NB-1:0] mRdy = '0;
  logic mActive = 0, mTx = 0, mErr = 0;
  int mCur = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_tx_scheduler dut (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .submitIn(submitIn),
    .noRetry(noRetry), .busIdle(busIdle), .busOff(busOff),
    .txDone(txDone), .arbLost(arbLost), .txErr(txErr),
    .txIe(txIe), .errIe(errIe), .flagClr(flagClr),
    .startReq(startReq), .startIdx(startIdx), .rdyOut(rdyOut),
    .busyOut(busyOut), .txFlag(txFlag), .errFlag(errFlag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int topPending(input logic [NB-1:0] p);
    int r = -1;
    for (int i = 0; i < NB; i++) if (p[i]) r = i;
    return r;
  endfunction

  function automatic logic [NB-1:0] busyMask();
    return mActive ? (NB'(1) << mCur) : '0;
  endfunction

  task automatic step(input logic [NB-1:0] lk, input logic [NB-1:0] sb,
                      input logic idl, input logic off, input logic nr,
                      input logic dn, input logic al, input logic er,
                      input logic [1:0] clr);
    logic [NB-1:0] pend;
    logic expStart, drop, setTx, setErr;
    int sel;
    @(negedge clk);
    lockIn = lk; submitIn = sb; busIdle = idl; busOff = off; noRetry = nr;
    txDone = dn; arbLost = al; txErr = er; flagClr = clr;
    pend = mRdy & lk;
    sel = topPending(pend);
    expStart = !mActive && idl && !off && (pend != 0);
    #1;
    chk("R4 startReq", startReq, expStart);
    if (expStart) chk("R3 startIdx", startIdx, sel);
    drop = 0; setTx = 0; setErr = 0;
    if (!mActive) begin
      if (expStart) begin mActive = 1; mCur = sel; end
    end else if (off) begin
      drop = 1; mActive = 0;
    end else if (!lk[mCur]) begin
      mActive = 0;
    end else if (dn) begin
      drop = 1; setTx = 1; mActive = 0;
    end else if (al || er) begin
      setErr = 1; drop = nr; mActive = 0;
    end else if (sel > mCur) begin
      mActive = 0;
    end
    for (int i = 0; i < NB; i++) begin
      if (off || !lk[i]) mRdy[i] = 0;
      else if (drop && i == mCur) mRdy[i] = 0;
      else if (sb[i]) mRdy[i] = 1;
    end
    mTx  = setTx  | (mTx  & ~clr[0]);
    mErr = setErr | (mErr & ~clr[1]);
    @(posedge clk); #1;
    chk("R1 rdyOut", rdyOut, mRdy);
    chk("R4 busyOut", busyOut, busyMask());
    chk("R7 txFlag", txFlag, mTx);
    chk("R5 errFlag", errFlag, mErr);
    chk("R11 irq", irq, (mTx & txIe) | (mErr & errIe));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    chk("R4 reset startReq", startReq, 0);
    chk("R1 reset rdy", rdyOut, 0);
    chk("R4 reset busy", busyOut, 0);
    chk("R10 reset flags", {txFlag, errFlag}, 0);
    chk("R11 reset irq", irq, 0);

    // R1: submit ignored without lock
    step(3'b000, 3'b010, 0,0,0, 0,0,0, 2'b00);
    chk("R1 unlocked submit ignored", rdyOut, 3'b000);
    // R12: results with no job in flight
    step(3'b111, 3'b000, 0,0,0, 1,1,0, 2'b00);
    chk("R12 idle result ignored", {txFlag, errFlag}, 2'b00);
    step(3'b111, 3'b111, 0,0,0, 0,0,0, 2'b00);
    chk("R1 submit sets ready", rdyOut, 3'b111);
    step(3'b111, 3'b000, 1,0,0, 0,0,0, 2'b00);
    chk("R3 highest buffer busy", busyOut, 3'b100);
    // R5: lost arbitration then retry
    step(3'b111, 3'b000, 0,0,0, 0,1,0, 2'b00);
    chk("R5 ready kept after failure", rdyOut, 3'b111);
    chk("R5 error flag", errFlag, 1);
    step(3'b111, 3'b000, 1,0,0, 0,0,0, 2'b00);
    chk("R5 retry same buffer", busyOut, 3'b100);
    // R7: completion
    step(3'b111, 3'b000, 0,0,0, 1,0,0, 2'b00);
    chk("R7 retired", {rdyOut, busyOut, txFlag}, {3'b011, 3'b000, 1'b1});
    // R9: pre-emption
    step(3'b111, 3'b000, 1,0,0, 0,0,0, 2'b00);
    step(3'b111, 3'b100, 0,0,0, 0,0,0, 2'b00);
    step(3'b111, 3'b000, 0,0,0, 0,0,0, 2'b00);
    chk("R9 preempted job kept", {rdyOut, busyOut}, {3'b111, 3'b000});
    step(3'b111, 3'b000, 1,0,0, 0,0,0, 2'b00);
    step(3'b111, 3'b000, 0,0,0, 1,0,0, 2'b00);
    // R9: completion coincides with pre-emption
    step(3'b111, 3'b000, 1,0,0, 0,0,0, 2'b11);
    step(3'b111, 3'b100, 0,0,0, 0,0,0, 2'b00);
    step(3'b111, 3'b000, 0,0,0, 1,0,0, 2'b00);
    chk("R9 completion wins", {rdyOut, busyOut, txFlag}, {3'b101, 3'b000, 1'b1});
    // R6: no retransmit
    step(3'b111, 3'b000, 1,0,0, 0,0,0, 2'b00);
    step(3'b111, 3'b000, 0,0,1, 0,0,1, 2'b00);
    chk("R6 job dropped", rdyOut, 3'b001);
    // R8: bus-off
    step(3'b111, 3'b011, 0,0,0, 0,0,0, 2'b00);
    step(3'b111, 3'b000, 1,1,0, 0,0,0, 2'b00);
    chk("R8 bus-off clears", {rdyOut, busyOut}, 6'b0);
    // R2: unlock while busy
    step(3'b111, 3'b001, 0,0,0, 0,0,0, 2'b00);
    step(3'b111, 3'b000, 1,0,0, 0,0,0, 2'b00);
    step(3'b110, 3'b000, 0,0,0, 0,0,0, 2'b00);
    chk("R2 unlock cancels", {rdyOut, busyOut}, 6'b0);
    // R10: write-one-to-clear, set wins over clear
    step(3'b111, 3'b000, 0,0,0, 0,0,0, 2'b01);
    chk("R10 tx cleared err kept", {txFlag, errFlag}, 2'b01);
    step(3'b111, 3'b001, 0,0,0, 0,0,0, 2'b00);
    step(3'b111, 3'b000, 1,0,0, 0,0,0, 2'b00);
    step(3'b111, 3'b000, 0,0,0, 0,0,1, 2'b10);
    chk("R10 set beats clear", errFlag, 1);
    // R11: gating
    txIe = 0; errIe = 1; #1;
    chk("R11 err enabled", irq, 1);
    errIe = 0; #1;
    chk("R11 all disabled", irq, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [NB-1:0] lk, sb;
      int r;
      if (n % 256 == 0) begin txIe = 1'($urandom); errIe = 1'($urandom); end
      for (int i = 0; i < NB; i++) begin
        lk[i] = ($urandom % 8) != 0;
        sb[i] = ($urandom % 6) == 0;
      end
      r = $urandom % 8;
      step(lk, sb, 1'($urandom), ($urandom % 64) == 0, ($urandom % 4) == 0,
           r == 0, r == 1, r == 2, (($urandom % 16) == 0) ? 2'($urandom) : 2'b00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule